// File: doc/BRIEF.md
# Three-Phase Hysteresis Current Controller

This block closes a bang-bang current loop around a three-phase inverter bridge. Each clock it takes a signed reference current for each of the three phases and two sampled phase currents. The third actual current is rebuilt as the negative sum of the two sensed ones, because the load currents sum to zero. For each leg the error is the reference minus the actual current. This error is compared against a tolerance band that is shared by all three legs. A leg drives its high-side switch to push current up and its low-side switch to pull it down. While the error stays inside the band, the leg keeps its present state. The switching rate is therefore not fixed: it follows the load.

Every change of direction in a leg passes through a dead-time gap in which both switches of that leg are off. A separate over-current monitor watches all three currents against a programmable trip level. When it trips, it forces every gate off and raises a fault flag that only a reset clears.

Top module: `hcc_pwm`

## Requirements
- R1: The third actual current equals -(meas_a_i + meas_b_i), computed with enough width to be exact over the full input range, including both inputs at the most negative code.
- R2: When ref - actual for a leg is greater than floor(band_i/2), that leg selects its high side.
- R3: When ref - actual for a leg is less than -floor(band_i/2), that leg selects its low side.
- R4: When the error lies within [-floor(band_i/2), +floor(band_i/2)], the boundaries included, the leg keeps its present selection.
- R5: Each leg depends only on its own reference and actual current. A selection change in one leg leaves the other legs' gates unchanged.
- R6: When a leg changes selection, both of its gates are off during the clock cycle after the deciding edge and during the DT_CYC-1 cycles that follow. The newly selected gate turns on in the next cycle. The two gates of a leg are never on together.
- R7: If the magnitude of any of the three currents is strictly greater than trip_i, fault_o is 1 in the cycle after the deciding edge and all six gates are 0. A magnitude equal to trip_i does not trip.
- R8: Once set, fault_o stays 1 and all gates stay off until rst_ni is asserted, whatever the currents do.
- R9: During reset and for DT_CYC cycles after its release, all gates are off and fault_o is 0. After that, every leg whose error is in band drives its low side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_a_i | input | CUR_W | Phase A reference current, signed |
| ref_b_i | input | CUR_W | Phase B reference current, signed |
| ref_c_i | input | CUR_W | Phase C reference current, signed |
| meas_a_i | input | CUR_W | Sensed phase A current, signed |
| meas_b_i | input | CUR_W | Sensed phase B current, signed |
| band_i | input | CUR_W | Full tolerance band width, unsigned |
| trip_i | input | CUR_W+1 | Over-current magnitude limit, unsigned |
| gate_hi_o | output | 3 | High-side gate per leg, bit 0 = A, bit 2 = C |
| gate_lo_o | output | 3 | Low-side gate per leg, bit 0 = A, bit 2 = C |
| fault_o | output | 1 | Sticky over-current flag |

## Verification
Leg A is driven with errors far above the band, exactly at +half and -half, and one count past -half. These cases separate strict thresholds from inclusive ones, and a hold from a switch. Equal sensed currents on A and B with zero references show that only leg C reacts, which confirms the derived current and the independence of the legs. Both sensors at the most negative code, with a high reference on C, distinguish an exact derived current from a wrapped one. Widening the band while a leg is high shows that an error inside the new band holds the state. A magnitude equal to the trip level, then one count above it, locates the trip threshold; the removed over-current then shows that the fault stays latched.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  typedef enum logic {
    DRV_LO = 1'b0,
    DRV_HI = 1'b1
  } drive_e;

  localparam int unsigned NUM_LEGS = 3;
endpackage

// File: rtl/hcc_leg.sv
module hcc_leg
  import hcc_pkg::*;
#(
  parameter int unsigned CUR_W  = 12,
  parameter int unsigned DT_CYC = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [CUR_W-1:0] ref_i,
  input  logic signed [CUR_W+1:0] act_i,
  input  logic        [CUR_W-1:0] band_i,
  input  logic                    kill_i,
  output logic                    hi_o,
  output logic                    lo_o
);
  localparam int unsigned ACT_W = CUR_W + 2;
  localparam int unsigned ERR_W = ACT_W + 1;
  localparam int unsigned CNT_W = $clog2(DT_CYC + 1);

  logic signed [ERR_W-1:0] err, half;
  drive_e                  dir_q, want;
  logic        [CNT_W-1:0] cnt_q;

  assign err  = {{(ERR_W-CUR_W){ref_i[CUR_W-1]}}, ref_i} - {act_i[ACT_W-1], act_i};
  assign half = {{(ERR_W-CUR_W){1'b0}}, band_i >> 1};

  always_comb begin
    if (err > half)       want = DRV_HI;
    else if (err < -half) want = DRV_LO;
    else                  want = dir_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DRV_LO;
      cnt_q <= CNT_W'(DT_CYC);
    end else if (want != dir_q) begin
      dir_q <= want;
      cnt_q <= CNT_W'(DT_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign hi_o = !kill_i && (cnt_q == '0) && (dir_q == DRV_HI);
  assign lo_o = !kill_i && (cnt_q == '0) && (dir_q == DRV_LO);

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o)); // R6
  AST_HI_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_o) |-> !$past(lo_o)); // R6
  AST_LO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_o) |-> !$past(hi_o)); // R6
  AST_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err > half) |=> (dir_q == DRV_HI)); // R2
  AST_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err < -half) |=> (dir_q == DRV_LO)); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err <= half && err >= -half) |=> $stable(dir_q)); // R4
endmodule

// File: rtl/hcc_trip.sv
module hcc_trip
  import hcc_pkg::*;
#(
  parameter int unsigned CUR_W = 12
) (
  input  logic signed [CUR_W+1:0] cur_i [NUM_LEGS],
  input  logic        [CUR_W:0]   trip_i,
  output logic                    over_o
);
  localparam int unsigned ACT_W = CUR_W + 2;

  logic [ACT_W-1:0]    mag [NUM_LEGS];
  logic [NUM_LEGS-1:0] hit;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_mag
    assign mag[g] = cur_i[g][ACT_W-1] ? ACT_W'(-cur_i[g]) : ACT_W'(cur_i[g]);
    assign hit[g] = mag[g] > {1'b0, trip_i};
  end

  assign over_o = |hit;
endmodule

// File: rtl/hcc_pwm.sv
module hcc_pwm
  import hcc_pkg::*;
#(
  parameter int unsigned CUR_W  = 12,
  parameter int unsigned DT_CYC = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [CUR_W-1:0] ref_a_i,
  input  logic signed [CUR_W-1:0] ref_b_i,
  input  logic signed [CUR_W-1:0] ref_c_i,
  input  logic signed [CUR_W-1:0] meas_a_i,
  input  logic signed [CUR_W-1:0] meas_b_i,
  input  logic        [CUR_W-1:0] band_i,
  input  logic        [CUR_W:0]   trip_i,
  output logic        [2:0]       gate_hi_o,
  output logic        [2:0]       gate_lo_o,
  output logic                    fault_o
);
  localparam int unsigned ACT_W = CUR_W + 2;

  logic signed [ACT_W-1:0] act [NUM_LEGS];
  logic signed [CUR_W-1:0] refs [NUM_LEGS];
  logic                    over, fault_q;

  // Two extra bits keep -(a+b) exact at both inputs = most negative code
  assign act[0]  = ACT_W'(meas_a_i);
  assign act[1]  = ACT_W'(meas_b_i);
  assign act[2]  = -(act[0] + act[1]);
  assign refs[0] = ref_a_i;
  assign refs[1] = ref_b_i;
  assign refs[2] = ref_c_i;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hcc_leg #(.CUR_W(CUR_W), .DT_CYC(DT_CYC)) i_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (refs[g]),
      .act_i  (act[g]),
      .band_i (band_i),
      .kill_i (fault_q),
      .hi_o   (gate_hi_o[g]),
      .lo_o   (gate_lo_o[g])
    );
  end

  hcc_trip #(.CUR_W(CUR_W)) i_trip (
    .cur_i  (act),
    .trip_i (trip_i),
    .over_o (over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fault_q <= 1'b0;
    else if (over) fault_q <= 1'b1;
  end

  assign fault_o = fault_q;

  AST_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over |=> fault_o); // R7
  AST_FAULT_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000)); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o); // R8
endmodule

// File: tb/test_hcc_pwm.sv
module test_hcc_pwm;
  localparam int CUR_W = 12;
  localparam int DT    = 3;

  logic clk = 0, rst_n = 0;
  logic signed [CUR_W-1:0] ra = 0, rb = 0, rc = 0, ma = 0, mb = 0;
  logic [CUR_W-1:0] band = 100;
  logic [CUR_W:0]   trip = 8191;
  logic [2:0] ghi, glo;
  logic       flt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hcc_pwm #(.CUR_W(CUR_W), .DT_CYC(DT)) i_hcc_pwm (
    .clk_i(clk), .rst_ni(rst_n),
    .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
    .meas_a_i(ma), .meas_b_i(mb),
    .band_i(band), .trip_i(trip),
    .gate_hi_o(ghi), .gate_lo_o(glo), .fault_o(flt)
  );

  // Behavioural reference model
  int m_dir [3];
  int m_cnt [3];
  int m_flt;

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_dir[i] = 0; m_cnt[i] = DT; end
      m_flt = 0;
    end else begin
      int cur [3];
      int rf [3];
      int h;
      cur[0] = int'(ma); cur[1] = int'(mb); cur[2] = -(int'(ma) + int'(mb));
      rf[0] = int'(ra); rf[1] = int'(rb); rf[2] = int'(rc);
      h = int'(band) / 2;
      for (int i = 0; i < 3; i++) begin
        int e, w;
        e = rf[i] - cur[i];
        w = (e > h) ? 1 : (e < -h) ? 0 : m_dir[i];
        if (w != m_dir[i]) begin m_dir[i] = w; m_cnt[i] = DT; end
        else if (m_cnt[i] > 0) m_cnt[i]--;
      end
      for (int i = 0; i < 3; i++)
        if (iabs(cur[i]) > int'(trip)) m_flt = 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Compare against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] eh, el;
      for (int i = 0; i < 3; i++) begin
        eh[i] = (m_flt == 0) && (m_cnt[i] == 0) && (m_dir[i] == 1);
        el[i] = (m_flt == 0) && (m_cnt[i] == 0) && (m_dir[i] == 0);
      end
      chk({ghi, glo} == {eh, el}, "model gates R2 R3 R4 R6", int'({ghi, glo}), int'({eh, el}));
      chk(flt == 1'(m_flt), "model fault R7 R8", int'(flt), m_flt);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    cyc(3);
    chk(ghi == 0 && glo == 0 && flt == 0, "R9 reset", int'({flt, ghi, glo}), 0);
    rst_n = 1;
    cyc(1);
    chk(glo == 0, "R9 gap after reset", int'(glo), 0);
    cyc(DT - 1);
    chk(glo == 3'b111 && ghi == 0, "R9 low after gap", int'({ghi, glo}), 7);

    // R2: error 200 > 50
    ra = 200;
    cyc(1);
    chk(ghi[0] == 0 && glo[0] == 0, "R6 dead time", int'({ghi[0], glo[0]}), 0);
    cyc(DT);
    chk(ghi[0] == 1 && glo[0] == 0, "R2 raise", int'({ghi[0], glo[0]}), 2);

    // R4: boundaries hold
    ra = 50;
    cyc(5);
    chk(ghi[0] == 1, "R4 at +half", int'(ghi[0]), 1);
    ra = -50;
    cyc(5);
    chk(ghi[0] == 1, "R4 at -half", int'(ghi[0]), 1);

    // R3: one past -half
    ra = -51;
    cyc(1);
    chk(ghi[0] == 0 && glo[0] == 0, "R6 gap on lower", int'({ghi[0], glo[0]}), 0);
    cyc(DT);
    chk(glo[0] == 1 && ghi[0] == 0, "R3 lower", int'({ghi[0], glo[0]}), 1);

    // R1 R5: derived C current -200, only leg C should rise
    ra = -60; rb = 0; rc = 0; ma = 100; mb = 100;
    cyc(DT + 1);
    chk(ghi == 3'b100 && glo == 3'b011, "R1 R5 derived leg", int'({ghi, glo}), 'b100011);

    // R4: wider band holds high
    band = 500; rc = -60;
    cyc(DT + 2);
    chk(ghi[2] == 1, "R4 wide band hold", int'(ghi[2]), 1);

    // R1: extreme inputs, derived = 4096
    band = 100; ma = -2048; mb = -2048; ra = -2048; rb = -2048; rc = 2047;
    cyc(DT + 1);
    chk(glo == 3'b111 && ghi == 0, "R1 exact derived", int'({ghi, glo}), 7);

    // R7: equal to trip does not trip, one above does
    trip = 500; ma = 500; mb = 0; ra = 0; rb = 0; rc = 0;
    cyc(1);
    chk(flt == 0, "R7 equal no trip", int'(flt), 0);
    ma = 501;
    cyc(1);
    chk(flt == 1 && ghi == 0 && glo == 0, "R7 trip", int'({flt, ghi, glo}), 64);

    // R8: sticky
    ma = 0; mb = 0; ra = 200;
    cyc(10);
    chk(flt == 1 && ghi == 0 && glo == 0, "R8 sticky", int'({flt, ghi, glo}), 64);

    rst_n = 0;
    cyc(1);
    chk(flt == 0 && ghi == 0 && glo == 0, "R9 reset clears", int'({flt, ghi, glo}), 0);
    cyc(1);
    finish_run();
  end
endmodule